// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block turns fetch and data-access requests from a processor core into the pin-level activity of a multiplexed external memory bus. The code space and the data space each span 64 KB. One bidirectional 8-bit port carries the low address byte and then the data byte of each access. A second 8-bit port carries the high address byte. An active-high address-latch strobe tells an external latch when the low address is valid. An active-low program-store strobe gates external code memory. Separate active-low read and write strobes serve external data memory.

Time is divided into fixed bus slots of six oscillator clocks. The address-latch strobe pulses once per slot, so it runs at one sixth of the oscillator rate. The core offers one request per slot and sees it taken through `req_take_o`. A code read goes off-chip when the external-access pin is low or when its address lies beyond the internal code store. Otherwise the slot runs internally and only the latch strobe toggles. A data access occupies two slots. The second latch pulse is dropped, and a single read or write strobe covers the interval where that pulse and the two program-store pulses would have been.

Top module: `ext_bus_seq`

## Requirements
- R1: Outside the second slot of a data access, `ale_o` is high for the first two clocks of every six-clock slot and low for the other four.
- R2: Requests are sampled at the clock edge that ends a slot, and `req_take_o` is high in the last clock of that slot. The request codes on `req_i` are: 0 none, 1 instruction fetch (address from `pc_i`), 2 table read (address from `dptr_i`), 3 data read and 4 data write (address from `dptr_i`). Any other code is treated as none.
- R3: In an external slot, `p0_o` drives the low address byte with `p0_oe_o` high during slot clocks 0 to 2, which is the latch pulse plus one clock after its falling edge. `p2_o` holds the high address byte for the whole external access and is 0xFF in every other slot.
- R4: A data access spans two consecutive slots and produces no latch pulse in its second slot. `req_take_o` stays low at the end of its first slot, and a request offered there has no effect.
- R5: In an external code slot, `psen_no` is low during slot clocks 3 to 5. This holds for instruction fetches and for table reads.
- R6: A code read is external when `ea_ni` is low or when its address is 0x8000 or above. An internal code slot keeps `psen_no` high, releases port 0 and sets `p2_o` to 0xFF.
- R7: For a data read, `rd_no` is low from clock 3 of the first slot to the end of the second slot (nine clocks), and port 0 is released for that whole time. The byte on `p0_i` in the last clock of a data read or an external code slot appears on `rdata_o`, with `rvalid_o` high, in the first clock of the next slot.
- R8: For a data write, `wr_no` is low over the same nine clocks, and `p0_o` drives the write data (`wdata_i`, sampled with the request) for the full strobe width.
- R9: At most one of `psen_no`, `rd_no` and `wr_no` is low at any time.
- R10: While `rst_ni` is low, `ctrl_oe_o` is low (the latch and program-store pads are released to their pull-ups), `ale_o` is high, every active-low strobe is high and port 0 is released. `ctrl_oe_o` rises at the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ea_ni | input | 1 | External-access pin; low forces all code reads off-chip |
| req_i | input | 3 | Request code offered for the next slot |
| pc_i | input | 16 | Program counter, the address of an instruction fetch |
| dptr_i | input | 16 | Data pointer, the address of table reads and data accesses |
| wdata_i | input | 8 | Write data |
| p0_i | input | 8 | Port 0 pad input |
| req_take_o | output | 1 | Request on `req_i` is taken at the next edge |
| p0_o | output | 8 | Port 0 drive value: low address or write data |
| p0_oe_o | output | 1 | Port 0 output enable |
| p2_o | output | 8 | Port 2 drive value: high address byte |
| ale_o | output | 1 | Address-latch strobe, active high |
| psen_no | output | 1 | Program-store strobe, active low |
| rd_no | output | 1 | External data read strobe, active low |
| wr_no | output | 1 | External data write strobe, active low |
| ctrl_oe_o | output | 1 | Drive enable of the latch and program-store pads |
| rdata_o | output | 8 | Byte captured from port 0 |
| rvalid_o | output | 1 | `rdata_o` holds a newly captured byte |

## Verification
The bench uses the default parameters: a six-clock slot, a two-clock latch pulse, one clock of address hold and a 32 KB internal code store. With these values a single slot, or a two-slot data access, can be checked clock by clock against an expected pin pattern worked out in the bench. The sweep runs every request kind at both levels of the external-access pin. It uses addresses on both sides of the 0x7FFF/0x8000 boundary, and gives the program counter and the data pointer different values so that the bench can see which one supplies the address. During each data access the bench offers a stray request at the end of the first slot, to confirm that the block ignores it.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {
    SL_IDLE     = 3'd0,
    SL_CODE_INT = 3'd1,
    SL_CODE_EXT = 3'd2,
    SL_DATA_A   = 3'd3,
    SL_DATA_B   = 3'd4
  } slot_e;

  localparam logic [2:0] REQ_NONE  = 3'd0;
  localparam logic [2:0] REQ_FETCH = 3'd1;
  localparam logic [2:0] REQ_TABLE = 3'd2;
  localparam logic [2:0] REQ_RD    = 3'd3;
  localparam logic [2:0] REQ_WR    = 3'd4;
endpackage

// File: rtl/bus_seq_phase.sv
module bus_seq_phase #(
  parameter int SLOT_CLKS = 6,
  localparam int PH_W = $clog2(SLOT_CLKS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] ph_o,
  output logic            slot_end_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(SLOT_CLKS - 1);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ph_q <= '0;
    else if (ph_q == LAST) ph_q <= '0;
    else                  ph_q <= ph_q + 1'b1;
  end

  assign ph_o       = ph_q;
  assign slot_end_o = (ph_q == LAST);

  p_phase_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= LAST);
  p_phase_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_end_o |=> (ph_q == '0));
endmodule

// File: rtl/bus_seq_slot.sv
module bus_seq_slot
  import bus_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int INT_CODE_BYTES = 32768
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slot_end_i,
  input  logic          ea_ni,
  input  logic [2:0]    req_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] dptr_i,
  input  logic [DW-1:0] wdata_i,
  output slot_e         kind_o,
  output logic          wr_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wd_o,
  output logic          req_take_o
);
  slot_e         kind_q;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;

  function automatic logic code_ext(input logic ea_n, input logic [AW-1:0] a);
    return !ea_n || (32'(a) >= 32'(INT_CODE_BYTES));
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= SL_IDLE;
      wr_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (slot_end_i) begin
      if (kind_q == SL_DATA_A) begin
        kind_q <= SL_DATA_B;
      end else begin
        unique case (req_i)
          REQ_FETCH: begin
            addr_q <= pc_i;
            kind_q <= code_ext(ea_ni, pc_i) ? SL_CODE_EXT : SL_CODE_INT;
          end
          REQ_TABLE: begin
            addr_q <= dptr_i;
            kind_q <= code_ext(ea_ni, dptr_i) ? SL_CODE_EXT : SL_CODE_INT;
          end
          REQ_RD, REQ_WR: begin
            addr_q <= dptr_i;
            kind_q <= SL_DATA_A;
            wr_q   <= (req_i == REQ_WR);
            wd_q   <= wdata_i;
          end
          default: kind_q <= SL_IDLE;
        endcase
      end
    end
  end

  assign kind_o     = kind_q;
  assign wr_o       = wr_q;
  assign addr_o     = addr_q;
  assign wd_o       = wd_q;
  assign req_take_o = slot_end_i && (kind_q != SL_DATA_A);

  p_data_pair_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_end_i && kind_q == SL_DATA_A) |=> (kind_q == SL_DATA_B));
  p_hold_mid_slot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_end_i |=> $stable(kind_q) && $stable(addr_q));
endmodule

// File: rtl/bus_seq_pins.sv
module bus_seq_pins
  import bus_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int ALE_CLKS = 2,
  parameter int ADDR_HOLD = 1,
  parameter int PH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PH_W-1:0] ph_i,
  input  logic            slot_end_i,
  input  slot_e           kind_i,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wd_i,
  input  logic [DW-1:0]   p0_i,
  output logic [DW-1:0]   p0_o,
  output logic            p0_oe_o,
  output logic [AW-DW-1:0] p2_o,
  output logic            ale_o,
  output logic            psen_no,
  output logic            rd_no,
  output logic            wr_no,
  output logic [DW-1:0]   rdata_o,
  output logic            rvalid_o
);
  localparam logic [PH_W-1:0] ALE_END = PH_W'(ALE_CLKS);
  localparam logic [PH_W-1:0] STB_BEG = PH_W'(ALE_CLKS + ADDR_HOLD);

  logic          adr_win, ext, xfer, cap;
  logic [DW-1:0] rdata_q;
  logic          rvalid_q;

  assign adr_win = ph_i < STB_BEG;
  assign ext     = (kind_i == SL_CODE_EXT) || (kind_i == SL_DATA_A) || (kind_i == SL_DATA_B);
  // strobe window: tail of first data slot plus whole second slot
  assign xfer    = ((kind_i == SL_DATA_A) && !adr_win) || (kind_i == SL_DATA_B);

  assign ale_o   = (kind_i != SL_DATA_B) && (ph_i < ALE_END);
  assign psen_no = !((kind_i == SL_CODE_EXT) && !adr_win);
  assign rd_no   = !(xfer && !wr_i);
  assign wr_no   = !(xfer && wr_i);
  assign p2_o    = ext ? addr_i[AW-1:DW] : '1;

  always_comb begin
    p0_o    = '0;
    p0_oe_o = 1'b0;
    if (((kind_i == SL_CODE_EXT) || (kind_i == SL_DATA_A)) && adr_win) begin
      p0_o    = addr_i[DW-1:0];
      p0_oe_o = 1'b1;
    end else if (xfer && wr_i) begin
      p0_o    = wd_i;
      p0_oe_o = 1'b1;
    end
  end

  assign cap = slot_end_i && ((kind_i == SL_CODE_EXT) || ((kind_i == SL_DATA_B) && !wr_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= cap;
      if (cap) rdata_q <= p0_i;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  p_strobe_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({~psen_no, ~rd_no, ~wr_no}));
  p_addr_on_ale_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_o && ext) |-> p0_oe_o);
  p_no_ale_xfer_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == SL_DATA_B) |-> !ale_o);
  p_rd_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !p0_oe_o);
  p_wr_drive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> p0_oe_o);
  p_psen_after_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psen_no |-> (!ale_o && !p0_oe_o));
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import bus_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int SLOT_CLKS = 6,
  parameter int ALE_CLKS = 2,
  parameter int ADDR_HOLD = 1,
  parameter int INT_CODE_BYTES = 32768
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ea_ni,
  input  logic [2:0]    req_i,
  input  logic [15:0]   pc_i,
  input  logic [15:0]   dptr_i,
  input  logic [7:0]    wdata_i,
  input  logic [7:0]    p0_i,
  output logic          req_take_o,
  output logic [7:0]    p0_o,
  output logic          p0_oe_o,
  output logic [7:0]    p2_o,
  output logic          ale_o,
  output logic          psen_no,
  output logic          rd_no,
  output logic          wr_no,
  output logic          ctrl_oe_o,
  output logic [7:0]    rdata_o,
  output logic          rvalid_o
);
  localparam int PH_W = $clog2(SLOT_CLKS);

  logic [PH_W-1:0] ph;
  logic            slot_end, wr;
  slot_e           kind;
  logic [AW-1:0]   addr;
  logic [DW-1:0]   wd;
  logic            ctrl_oe_q;

  bus_seq_phase #(.SLOT_CLKS(SLOT_CLKS)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .ph_o(ph), .slot_end_o(slot_end)
  );

  bus_seq_slot #(.AW(AW), .DW(DW), .INT_CODE_BYTES(INT_CODE_BYTES)) u_slot (
    .clk_i(clk_i), .rst_ni(rst_ni), .slot_end_i(slot_end), .ea_ni(ea_ni),
    .req_i(req_i), .pc_i(pc_i), .dptr_i(dptr_i), .wdata_i(wdata_i),
    .kind_o(kind), .wr_o(wr), .addr_o(addr), .wd_o(wd), .req_take_o(req_take_o)
  );

  bus_seq_pins #(.AW(AW), .DW(DW), .ALE_CLKS(ALE_CLKS), .ADDR_HOLD(ADDR_HOLD),
                 .PH_W(PH_W)) u_pins (
    .clk_i(clk_i), .rst_ni(rst_ni), .ph_i(ph), .slot_end_i(slot_end),
    .kind_i(kind), .wr_i(wr), .addr_i(addr), .wd_i(wd), .p0_i(p0_i),
    .p0_o(p0_o), .p0_oe_o(p0_oe_o), .p2_o(p2_o), .ale_o(ale_o),
    .psen_no(psen_no), .rd_no(rd_no), .wr_no(wr_no),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  // strobe pads stay released to pull-ups until reset is gone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_oe_q <= 1'b0;
    else         ctrl_oe_q <= 1'b1;
  end
  assign ctrl_oe_o = ctrl_oe_q;

  p_pads_live_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ctrl_oe_o);
endmodule

// File: tb/ext_bus_seq_tb_top.sv
module ext_bus_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ea_ni = 1'b1;
  logic [2:0]  req_i = 3'd0;
  logic [15:0] pc_i = '0, dptr_i = '0;
  logic [7:0]  wdata_i = '0, p0_i = '0;
  logic        req_take_o, p0_oe_o, ale_o, psen_no, rd_no, wr_no, ctrl_oe_o, rvalid_o;
  logic [7:0]  p0_o, p2_o, rdata_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  ext_bus_seq dut_i (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // kind: 1 fetch, 2 table, 3 read, 4 write
  task automatic run_slot(input logic ea, input logic [2:0] kind, input logic [15:0] a);
    logic        data = (kind >= 3);
    logic        wr   = (kind == 4);
    logic        ext  = data || !ea || (a >= 16'h8000);
    logic [7:0]  wdv  = a[7:0] ^ 8'h3C;
    logic [7:0]  mem  = a[15:8] ^ a[7:0] ^ 8'h5A;
    int          len  = data ? 12 : 6;
    while (!req_take_o) @(negedge clk_i);
    chk("R2", "req_take", int'(req_take_o), 1);
    ea_ni   = ea;
    req_i   = kind;
    pc_i    = (kind == 1) ? a : ~a;
    dptr_i  = (kind == 1) ? ~a : a;
    wdata_i = wdv;
    p0_i    = mem;
    @(negedge clk_i);
    req_i = 3'd0;
    pc_i = 16'h0; dptr_i = 16'hFFFF; wdata_i = 8'h00;
    for (int n = 0; n < len; n++) begin
      int  ph  = n % 6;
      bit  sec = (n >= 6);
      bit  stb = data && (n >= 3);
      bit  e_ale  = (ph < 2) && !(data && sec);
      bit  e_psen = !(!data && ext && ph >= 3);
      bit  e_rd   = !(stb && !wr);
      bit  e_wr   = !(stb && wr);
      bit  e_oe   = (ext && !data && ph < 3) || (data && n < 3) || (stb && wr);
      chk(data ? "R4" : "R1", "ale", int'(ale_o), int'(e_ale));
      chk(ext ? "R5" : "R6", "psen_n", int'(psen_no), int'(e_psen));
      chk("R7", "rd_n", int'(rd_no), int'(e_rd));
      chk("R8", "wr_n", int'(wr_no), int'(e_wr));
      chk("R9", "strobe_overlap", int'($countones({~psen_no, ~rd_no, ~wr_no}) <= 1), 1);
      chk(ext ? "R3" : "R6", "p0_oe", int'(p0_oe_o), int'(e_oe));
      if (e_oe) chk(stb ? "R8" : "R3", "p0", int'(p0_o), stb ? int'(wdv) : int'(a[7:0]));
      chk(ext ? "R3" : "R6", "p2", int'(p2_o), ext ? int'(a[15:8]) : 8'hFF);
      if (data && n == 5) begin
        chk("R4", "req_take_mid", int'(req_take_o), 0);
        req_i = 3'd1; pc_i = 16'h8000; dptr_i = ~a; wdata_i = ~wdv;  // stray request
      end
      if (data && n == 6) begin
        req_i = 3'd0; pc_i = 16'h0; dptr_i = 16'hFFFF; wdata_i = 8'h00;
      end
      @(negedge clk_i);
    end
    if ((!data && ext) || (data && !wr)) begin
      chk("R7", "rvalid", int'(rvalid_o), 1);
      chk("R7", "rdata", int'(rdata_o), int'(mem));
    end else begin
      chk("R7", "rvalid_none", int'(rvalid_o), 0);
    end
  endtask

  initial begin
    logic [15:0] addrs [6] = '{16'h0000, 16'h1234, 16'h7FFF, 16'h8000, 16'hA5C3, 16'hFFFF};
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10", "ctrl_oe", int'(ctrl_oe_o), 0);
    chk("R10", "ale", int'(ale_o), 1);
    chk("R10", "psen_n", int'(psen_no), 1);
    chk("R10", "rd_wr_n", int'({rd_no, wr_no}), 3);
    chk("R10", "p0_oe", int'(p0_oe_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10", "ctrl_oe_after", int'(ctrl_oe_o), 1);
    for (int ea = 0; ea < 2; ea++)
      for (int k = 1; k <= 4; k++)
        for (int i = 0; i < 6; i++)
          run_slot(ea[0], k[2:0], addrs[i]);
    // back-to-back data accesses
    run_slot(1'b1, 3'd4, 16'h4321);
    run_slot(1'b1, 3'd3, 16'h4321);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule